// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block ranks interrupt requests from four timer channels by fixed priority and joins a priority daisy chain. A channel raises a request with a one-cycle set pulse. The block drives an interrupt line toward the processor. When the processor acknowledges, the block answers with an 8-bit vector and marks the channel it chose as in service. A return-from-interrupt strobe then ends service for the highest-priority channel that is in service. The chain enable input lets an upstream device block this one. The chain enable output blocks downstream devices while any local channel is in service. An acknowledge or return strobe that no local channel claims is passed on to the downstream device as a one-cycle pulse.

Each channel runs its own four-state machine: `CH_IDLE`, `CH_PEND` (request waiting), `CH_SERV` (in service) and `CH_SERV_PEND` (in service with a new request waiting). The transitions are:
- set: `CH_IDLE`→`CH_PEND` and `CH_SERV`→`CH_SERV_PEND`.
- clear: `CH_PEND`→`CH_IDLE` and `CH_SERV_PEND`→`CH_SERV`.
- grant: `CH_PEND`→`CH_SERV`, or `CH_PEND`→`CH_SERV_PEND` when a set arrives in the same cycle.
- release: `CH_SERV` or `CH_SERV_PEND` go to `CH_IDLE`, or to `CH_PEND` when a set arrives in the same cycle.

The acknowledge answer is held in a response state machine with four states: `RSP_NONE`, `RSP_VEC` (vector issued), `RSP_BUSY` (0xFF issued) and `RSP_PASS` (acknowledge forwarded). Every acknowledge moves it to one of the last three for exactly one cycle. Every other cycle it returns to `RSP_NONE`.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: After reset, `int_o` is 0, `ieo` is 1, `vec_valid`, `ack_fwd` and `reti_fwd` are 0, no channel is pending or in service, and channel k answers with vector value k*2.
- R2: `ieo` is 1 one cycle after a cycle in which `iei` is 1 and, after that cycle's updates, no channel is in service. Otherwise `ieo` is 0.
- R3: `int_o` is 1 one cycle after a cycle in which `iei` is 1 and, after that cycle's updates, the lowest-numbered channel that is active (pending or in service) is pending and not in service. Otherwise `int_o` is 0.
- R4: When `ack` is high and the lowest-numbered active channel k is only pending, then in the next cycle `vec_valid` is 1 and `vec_out` is {field[7:3], k[1:0] in bits 2:1, 0 in bit 0}. Channel k's request is cleared and k enters service.
- R5: When `ack` is high and the lowest-numbered active channel is in service, then in the next cycle `vec_valid` is 1, `vec_out` is 8'hFF, and no channel state changes.
- R6: When `ack` is high and no channel is active, then in the next cycle `ack_fwd` is 1 and `vec_valid` is 0.
- R7: A `vec_wr` pulse loads `vec_data[7:3]` as the shared vector field [7:3] of all channels. `vec_data[2:0]` is ignored.
- R8: On `reti` (without `ack`), the lowest-numbered in-service channel leaves service and its waiting request is dropped. If no channel is in service, `reti_fwd` pulses in the next cycle.
- R9: A set pulse and a clear strobe on the same channel in the same cycle leave the request pending.
- R10: A clear strobe removes a waiting request without touching the service state.
- R11: When `ack` and `reti` arrive in the same cycle, the acknowledge is served and the `reti` is neither applied nor forwarded.
- R12: Channel 0 has the highest priority and channel 3 the lowest: with several channels pending, an acknowledge picks the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 4 | Per-channel request-set pulse |
| req_clr | input | 4 | Per-channel request-clear strobe |
| vec_wr | input | 1 | Vector field write strobe |
| vec_data | input | 8 | Vector write data; bits 7:3 are used |
| iei | input | 1 | Chain enable from upstream |
| ack | input | 1 | Interrupt acknowledge strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| int_o | output | 1 | Interrupt request to the processor (active high) |
| ieo | output | 1 | Chain enable to downstream |
| vec_out | output | 8 | Vector byte answering an acknowledge |
| vec_valid | output | 1 | `vec_out` is valid (one cycle) |
| ack_fwd | output | 1 | Acknowledge passed downstream |
| reti_fwd | output | 1 | Return strobe passed downstream |

## Verification
The bench builds the block with its default parameters: four channels and an 8-bit vector. With these values the channel number lands in bits 2:1 under a 5-bit shared field, so the exact vectors 0x00 through 0x06 after reset and 0xAC/0xAE after a field write can be checked. With only four channels, every priority contest can be reached in a few cycles: the in-service blocking that yields 0xFF, the forwarding of an unclaimed acknowledge or return strobe, and pending requests ranked past a served channel.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;

    // Per-channel state: bit 1 = in service, bit 0 = request pending
    typedef enum logic [1:0] {
        CH_IDLE      = 2'b00,
        CH_PEND      = 2'b01,
        CH_SERV      = 2'b10,
        CH_SERV_PEND = 2'b11
    } ch_state_e;

    // Acknowledge response held for one cycle
    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_VEC  = 2'b01,
        RSP_BUSY = 2'b10,
        RSP_PASS = 2'b11
    } rsp_state_e;

endpackage

// File: rtl/irq_dc_chan.sv
module irq_dc_chan
    import irq_dc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic grant_i,
    input  logic release_i,
    output logic pend_o,
    output logic serv_o,
    output logic pend_nx_o,
    output logic serv_nx_o
);

    ch_state_e state_q;
    ch_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Set wins over clear, grant and release happening in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (set_i) state_d = CH_PEND;
            end
            CH_PEND: begin
                if (grant_i)    state_d = set_i ? CH_SERV_PEND : CH_SERV;
                else if (set_i) state_d = CH_PEND;
                else if (clr_i) state_d = CH_IDLE;
            end
            CH_SERV: begin
                if (release_i)  state_d = set_i ? CH_PEND : CH_IDLE;
                else if (set_i) state_d = CH_SERV_PEND;
            end
            CH_SERV_PEND: begin
                if (release_i)  state_d = set_i ? CH_PEND : CH_IDLE;
                else if (set_i) state_d = CH_SERV_PEND;
                else if (clr_i) state_d = CH_SERV;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        pend_o    = state_q[0];
        serv_o    = state_q[1];
        pend_nx_o = state_d[0];
        serv_nx_o = state_d[1];
    end

endmodule

// File: rtl/irq_dc_scan.sv
module irq_dc_scan #(
    parameter int N_CH = 4,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] pend_i,
    input  logic [N_CH-1:0] serv_i,
    output logic            hit_o,
    output logic [CH_W-1:0] hit_idx_o,
    output logic            hit_serv_o,
    output logic            svc_any_o,
    output logic [CH_W-1:0] svc_idx_o
);

    // Scan high to low so the lowest index (highest priority) is kept
    always_comb begin
        hit_o      = 1'b0;
        hit_idx_o  = '0;
        hit_serv_o = 1'b0;
        svc_any_o  = 1'b0;
        svc_idx_o  = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (pend_i[i] || serv_i[i]) begin
                hit_o      = 1'b1;
                hit_idx_o  = CH_W'(i);
                hit_serv_o = serv_i[i];
            end
            if (serv_i[i]) begin
                svc_any_o = 1'b1;
                svc_idx_o = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
    import irq_dc_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  req_set,
    input  logic [N_CH-1:0]  req_clr,
    input  logic             vec_wr,
    input  logic [VEC_W-1:0] vec_data,
    input  logic             iei,
    input  logic             ack,
    input  logic             reti,
    output logic             int_o,
    output logic             ieo,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             ack_fwd,
    output logic             reti_fwd
);

    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int HI_W = VEC_W - 1 - CH_W;

    logic [N_CH-1:0] pend, serv, pend_nx, serv_nx;
    logic [N_CH-1:0] grant, rel;

    logic            cur_hit, cur_hit_serv, cur_svc_any;
    logic [CH_W-1:0] cur_hit_idx, cur_svc_idx;
    logic            nx_hit, nx_hit_serv, nx_svc_any;
    logic [CH_W-1:0] nx_idx_unused, nx_svc_idx_unused;

    logic [HI_W-1:0]  vec_hi_q;
    logic             vec_lo_unused;
    rsp_state_e       rsp_q, rsp_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic             int_q, ieo_q, rfwd_q;

    assign vec_lo_unused = ^vec_data[VEC_W-HI_W-1:0];

    // Scan of the current state decides grants and releases
    irq_dc_scan #(.N_CH(N_CH)) u_scan_cur (
        .pend_i     (pend),
        .serv_i     (serv),
        .hit_o      (cur_hit),
        .hit_idx_o  (cur_hit_idx),
        .hit_serv_o (cur_hit_serv),
        .svc_any_o  (cur_svc_any),
        .svc_idx_o  (cur_svc_idx)
    );

    // Scan of the next state feeds the registered chain outputs
    irq_dc_scan #(.N_CH(N_CH)) u_scan_nx (
        .pend_i     (pend_nx),
        .serv_i     (serv_nx),
        .hit_o      (nx_hit),
        .hit_idx_o  (nx_idx_unused),
        .hit_serv_o (nx_hit_serv),
        .svc_any_o  (nx_svc_any),
        .svc_idx_o  (nx_svc_idx_unused)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign grant[c] = ack && cur_hit && !cur_hit_serv && (cur_hit_idx == CH_W'(c));
            assign rel[c]   = reti && !ack && cur_svc_any && (cur_svc_idx == CH_W'(c));

            irq_dc_chan u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (req_set[c]),
                .clr_i     (req_clr[c]),
                .grant_i   (grant[c]),
                .release_i (rel[c]),
                .pend_o    (pend[c]),
                .serv_o    (serv[c]),
                .pend_nx_o (pend_nx[c]),
                .serv_nx_o (serv_nx[c])
            );
        end
    endgenerate

    // Response next state
    always_comb begin
        rsp_d = RSP_NONE;
        vec_d = '1;
        if (ack) begin
            if (!cur_hit) begin
                rsp_d = RSP_PASS;
            end else if (cur_hit_serv) begin
                rsp_d = RSP_BUSY;
            end else begin
                rsp_d = RSP_VEC;
                vec_d = {vec_hi_q, cur_hit_idx, 1'b0};
            end
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q    <= RSP_NONE;
            vec_q    <= '1;
            vec_hi_q <= '0;
            int_q    <= 1'b0;
            ieo_q    <= 1'b1;
            rfwd_q   <= 1'b0;
        end else begin
            rsp_q  <= rsp_d;
            vec_q  <= vec_d;
            if (vec_wr) vec_hi_q <= vec_data[VEC_W-1 -: HI_W];
            int_q  <= iei && nx_hit && !nx_hit_serv;
            ieo_q  <= iei && !nx_svc_any;
            rfwd_q <= reti && !ack && !cur_svc_any;
        end
    end

    // Output process
    always_comb begin
        int_o     = int_q;
        ieo       = ieo_q;
        reti_fwd  = rfwd_q;
        vec_valid = 1'b0;
        ack_fwd   = 1'b0;
        vec_out   = '1;
        unique case (rsp_q)
            RSP_NONE: ;
            RSP_VEC: begin
                vec_valid = 1'b1;
                vec_out   = vec_q;
            end
            RSP_BUSY: vec_valid = 1'b1;
            RSP_PASS: ack_fwd = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_dc_chk.sv
module irq_dc_chk (
    input logic clk,
    input logic rst_n,
    input logic iei,
    input logic ack,
    input logic reti,
    input logic int_o,
    input logic ieo,
    input logic vec_valid,
    input logic ack_fwd,
    input logic reti_fwd
);

    a_r2_ieo_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |=> !ieo);

    a_r3_int_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !iei |=> !int_o);

    a_r4_ack_answered: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (vec_valid || ack_fwd));

    a_r4_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> (!vec_valid && !ack_fwd));

    a_r6_fwd_excludes_vector: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fwd |-> !vec_valid);

    a_r8_reti_fwd_needs_reti: assert property (@(posedge clk) disable iff (!rst_n)
        !reti |=> !reti_fwd);

    a_r11_reti_dropped_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !reti_fwd);

endmodule

bind irq_daisy_ctrl irq_dc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iei       (iei),
    .ack       (ack),
    .reti      (reti),
    .int_o     (int_o),
    .ieo       (ieo),
    .vec_valid (vec_valid),
    .ack_fwd   (ack_fwd),
    .reti_fwd  (reti_fwd)
);

// File: tb/irq_daisy_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_daisy_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_set, req_clr;
    logic       vec_wr, iei, ack, reti;
    logic [7:0] vec_data;
    logic       int_o, ieo, vec_valid, ack_fwd, reti_fwd;
    logic [7:0] vec_out;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_daisy_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .vec_wr(vec_wr), .vec_data(vec_data), .iei(iei), .ack(ack), .reti(reti),
        .int_o(int_o), .ieo(ieo), .vec_out(vec_out), .vec_valid(vec_valid),
        .ack_fwd(ack_fwd), .reti_fwd(reti_fwd)
    );

    typedef struct packed {
        logic [3:0] set;
        logic [3:0] clr;
        logic       iei;
        logic       ack;
        logic       reti;
        logic       wr;
        logic [7:0] data;
        logic       e_int;
        logic       e_ieo;
        logic       e_val;
        logic [7:0] e_vec;
        logic       e_af;
        logic       e_rf;
    } row_t;

    localparam int NROW = 21;
    localparam row_t TBL [NROW] = '{
        // set   clr   iei  ack  reti wr   data   int  ieo  val  vec    af   rf
        '{4'h1, 4'h0, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R3 ch0 pending
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h00, 1'b0,1'b0}, // R4 grant ch0
        '{4'h2, 4'h0, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0}, // R3 blocked by svc
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'hFF, 1'b0,1'b0}, // R5 busy answer
        '{4'h0, 4'h0, 1'b1,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R8 ch0 leaves
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'h02, 1'b0,1'b0}, // R4 grant ch1
        '{4'h0, 4'h0, 1'b1,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R8 ch1 leaves
        '{4'h0, 4'h0, 1'b1,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1}, // R8 forward
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0}, // R6 forward
        '{4'h0, 4'h0, 1'b1,1'b0,1'b0,1'b1,8'hA9, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R7 write field
        '{4'hC, 4'h0, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R3 ch2,ch3
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'hAC, 1'b0,1'b0}, // R7 R12 ch2
        '{4'h0, 4'h0, 1'b1,1'b0,1'b1,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R8 ch2 leaves
        '{4'h0, 4'h0, 1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,8'hAE, 1'b0,1'b0}, // R4 ch3
        '{4'h0, 4'h0, 1'b0,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0}, // R2 iei low
        '{4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0}, // R3 iei low
        '{4'h0, 4'h0, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R2 R3 iei back
        '{4'h0, 4'h1, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R10 clear
        '{4'h2, 4'h2, 1'b1,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0}, // R9 set wins
        '{4'h0, 4'h0, 1'b1,1'b1,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b1,8'hAA, 1'b0,1'b0}, // R11 ack wins
        '{4'h0, 4'h0, 1'b1,1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0}  // R8 ch1 leaves
    };

    task automatic drive(input logic [3:0] s, input logic [3:0] c, input logic ie,
                         input logic a, input logic r, input logic w, input logic [7:0] d);
        req_set = s; req_clr = c; iei = ie; ack = a; reti = r; vec_wr = w; vec_data = d;
        @(posedge clk);
        #1;
        req_set = '0; req_clr = '0; ack = 1'b0; reti = 1'b0; vec_wr = 1'b0;
    endtask

    task automatic check(input string req, input logic e_int, input logic e_ieo,
                         input logic e_val, input logic [7:0] e_vec,
                         input logic e_af, input logic e_rf);
        logic ok;
        n_run++;
        ok = (int_o === e_int) && (ieo === e_ieo) && (vec_valid === e_val) &&
             (!e_val || vec_out === e_vec) && (ack_fwd === e_af) && (reti_fwd === e_rf);
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got int=%b ieo=%b val=%b vec=%h af=%b rf=%b exp int=%b ieo=%b val=%b vec=%h af=%b rf=%b",
                     req, int_o, ieo, vec_valid, vec_out, ack_fwd, reti_fwd,
                     e_int, e_ieo, e_val, e_vec, e_af, e_rf);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_set = '0; req_clr = '0; vec_wr = 1'b0; vec_data = '0;
        iei = 1'b1; ack = 1'b0; reti = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset outputs", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NROW; i++) begin
            drive(TBL[i].set, TBL[i].clr, TBL[i].iei, TBL[i].ack, TBL[i].reti,
                  TBL[i].wr, TBL[i].data);
            check($sformatf("table row %0d", i), TBL[i].e_int, TBL[i].e_ieo,
                  TBL[i].e_val, TBL[i].e_vec, TBL[i].e_af, TBL[i].e_rf);
        end

        // R1: reset again, vector field returns to zero, ch2 answers 0x04
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset again", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        drive(4'h4, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        drive(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R1 reset vector ch2", 1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);

        // R12: all four pending at once
        drive(4'hF, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        drive(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R12 ch0 first", 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        check("R8 release exposes ch1", 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R12 ch1 next", 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        drive(4'h0, 4'hC, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R10 clear ch2 ch3", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);

        // R8: reti drops a request that arrived during service
        drive(4'h1, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        drive(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        drive(4'h1, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check("R3 pending behind service", 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
        check("R8 request dropped", 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0);
        drive(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R6 nothing left", 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule